// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing bytes of a two-operand instruction into a resolved operand. It takes the mode/register/rm byte, an optional scale/index/base byte, the raw displacement bytes, an address-size select (16 or 32 bits), a snapshot of the eight general registers and the four segment register values. From these it decides whether the operand is a register or memory. For a memory operand it forms the effective offset and picks the segment, either from the base register in use or from an explicit override. It also forms the 20-bit real-mode physical address.

The block handles the irregular escape codes of the encoding: a bare displacement with no base, the "no index" code, and the codes that substitute a displacement for the frame-pointer base. All results are registered once, so they appear one clock after a valid input. Outputs hold their value while no valid input is presented.

General register numbering used throughout: 0=AX/EAX, 1=CX/ECX, 2=DX/EDX, 3=BX/EBX, 4=SP/ESP, 5=BP/EBP, 6=SI/ESI, 7=DI/EDI. Register i occupies bits [32*i+31:32*i] of `gpr_i`. Segment codes are 0=ES, 1=CS, 2=SS, 3=DS. Segment code s occupies bits [16*s+15:16*s] of `seg_vals_i`.

Top module: `ea_gen`

## Requirements
- R1: When mode bits [7:6] of `modrm_i` are 3, the operand is a register. `is_reg_o`=1, `reg_num_o`=bits [2:0], and `offset_o`, `phys_o`, `seg_o`, `disp_kind_o` and `sib_used_o` are 0. `reg_field_o` always carries bits [5:3] of the captured `modrm_i`.
- R2: `disp_kind_o` encodes the displacement consumed as 0=none, 1=8-bit, 2=16-bit, 3=32-bit. Mode 0 adds none, mode 1 adds `disp_i[7:0]` sign-extended, and mode 2 adds `disp_i[15:0]` in 16-bit mode or `disp_i[31:0]` in 32-bit mode. The escape cases in R4, R5 and R8 are exceptions.
- R3: In 16-bit mode, rm values 0..7 form the offset from BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX respectively, plus the displacement. `sib_i` is ignored in this mode.
- R4: In 16-bit mode, rm=6 with mode 0 gives a bare offset of `disp_i[15:0]` with no register, and `disp_kind_o`=2.
- R5: In 32-bit mode, rm values other than 4 and 5 use the register numbered rm as the base. rm=5 with mode 0 gives a bare offset of `disp_i` with `disp_kind_o`=3. rm=5 with mode 1 or 2 uses EBP as the base.
- R6: In 32-bit mode, rm=4 with mode not 3 uses `sib_i` (scale [7:6], index [5:3], base [2:0]). The offset is base + (index << scale) + displacement, and `sib_used_o`=1.
- R7: An index field of 4 (ESP) means no index, so the scaled term is zero.
- R8: A scale/index/base base field of 5 with mode 0 means no base register and a 32-bit displacement (`disp_kind_o`=3). With mode 1 or 2 the same field selects EBP.
- R9: Without an override, `seg_o` is SS (2) when the base register used is BP/EBP or SP/ESP, and DS (3) otherwise, including bare-displacement forms.
- R10: When `ovr_en_i`=1, a memory operand takes `seg_o`=`ovr_seg_i`.
- R11: The offset wraps modulo 2^16 in 16-bit mode (`offset_o[31:16]`=0) and modulo 2^32 in 32-bit mode.
- R12: For a memory operand, `phys_o` = (segment value of `seg_o` << 4) + `offset_o[15:0]`, modulo 2^20.
- R13: Results appear one clock after `valid_i`=1, and `valid_o` is `valid_i` delayed by one clock. While `valid_i`=0 all result outputs hold. Synchronous `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input bytes are valid this cycle |
| modrm_i | input | 8 | Mode [7:6], register field [5:3], rm [2:0] |
| sib_i | input | 8 | Scale [7:6], index [5:3], base [2:0] |
| disp_i | input | 32 | Raw displacement bytes, low-aligned |
| addr32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| gpr_i | input | 256 | Eight general registers, register i at [32i+31:32i] |
| seg_vals_i | input | 64 | Four segment values, code s at [16s+15:16s] |
| ovr_en_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| valid_o | output | 1 | Result valid |
| is_reg_o | output | 1 | Operand is a register |
| reg_num_o | output | 3 | Register operand number |
| reg_field_o | output | 3 | Captured register field of the mode byte |
| offset_o | output | 32 | Effective offset |
| seg_o | output | 2 | Segment code used |
| phys_o | output | 20 | Real-mode physical address |
| disp_kind_o | output | 2 | Displacement size consumed |
| sib_used_o | output | 1 | Scale/index/base byte consumed |

## Verification
The bound checker watches, on every cycle, the one-clock valid lag and the holding of results, the register-operand outcome, the 8-bit displacement kind, the upper-half clearing in 16-bit mode, the override segment, use of the scale/index/base byte, and the consistency of the physical address with the reported segment and offset. The actual offset arithmetic is checked only by the bench's reference model. That covers each rm row, the bare-displacement escapes, the no-index code, base substitution, shifted index terms and wrap-around near the top of the offset range, together with the default segment chosen from the base.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] REG_BX = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_SP = 3'd4;
  localparam logic [REG_IDX_W-1:0] REG_BP = 3'd5;
  localparam logic [REG_IDX_W-1:0] REG_SI = 3'd6;
  localparam logic [REG_IDX_W-1:0] REG_DI = 3'd7;

  localparam logic [1:0] SEG_SS = 2'd2;
  localparam logic [1:0] SEG_DS = 2'd3;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_8    = 2'd1,
    DSZ_16   = 2'd2,
    DSZ_32   = 2'd3
  } dsz_e;

  typedef struct packed {
    logic                 is_reg;
    logic [REG_IDX_W-1:0] reg_num;
    logic                 base_en;
    logic [REG_IDX_W-1:0] base_idx;
    logic                 index_en;
    logic [REG_IDX_W-1:0] index_idx;
    logic [1:0]           scale;
    dsz_e                 dsz;
    logic                 stack_seg;
    logic                 sib_used;
  } ea_dec_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  input  logic       addr32_i,
  output ea_dec_t    dec_o
);
  logic [1:0] md;
  logic [2:0] rm;
  logic [2:0] sib_base;
  logic [2:0] sib_index;

  assign md        = modrm_i[7:6];
  assign rm        = modrm_i[2:0];
  assign sib_base  = sib_i[2:0];
  assign sib_index = sib_i[5:3];

  always_comb begin
    dec_o = '0;
    if (md == 2'b11) begin
      dec_o.is_reg  = 1'b1;
      dec_o.reg_num = rm;
    end else begin
      case (md)
        2'b01:   dec_o.dsz = DSZ_8;
        2'b10:   dec_o.dsz = addr32_i ? DSZ_32 : DSZ_16;
        default: dec_o.dsz = DSZ_NONE;
      endcase
      if (!addr32_i) begin
        // 16-bit table: pairs for rm 0..3, single registers for 4..7
        dec_o.base_en = 1'b1;
        case (rm)
          3'd0: begin dec_o.base_idx = REG_BX; dec_o.index_en = 1'b1; dec_o.index_idx = REG_SI; end
          3'd1: begin dec_o.base_idx = REG_BX; dec_o.index_en = 1'b1; dec_o.index_idx = REG_DI; end
          3'd2: begin dec_o.base_idx = REG_BP; dec_o.index_en = 1'b1; dec_o.index_idx = REG_SI; end
          3'd3: begin dec_o.base_idx = REG_BP; dec_o.index_en = 1'b1; dec_o.index_idx = REG_DI; end
          3'd4: dec_o.base_idx = REG_SI;
          3'd5: dec_o.base_idx = REG_DI;
          3'd6: dec_o.base_idx = REG_BP;
          default: dec_o.base_idx = REG_BX;
        endcase
        if (rm == 3'd6 && md == 2'b00) begin
          dec_o.base_en = 1'b0;
          dec_o.dsz     = DSZ_16;
        end
      end else if (rm == 3'd4) begin
        dec_o.sib_used  = 1'b1;
        dec_o.scale     = sib_i[7:6];
        dec_o.index_en  = (sib_index != REG_SP);
        dec_o.index_idx = sib_index;
        if (sib_base == REG_BP && md == 2'b00) begin
          dec_o.base_en = 1'b0;
          dec_o.dsz     = DSZ_32;
        end else begin
          dec_o.base_en  = 1'b1;
          dec_o.base_idx = sib_base;
        end
      end else if (rm == 3'd5 && md == 2'b00) begin
        dec_o.dsz = DSZ_32;
      end else begin
        dec_o.base_en  = 1'b1;
        dec_o.base_idx = rm;
      end
      dec_o.stack_seg = dec_o.base_en &&
                        (dec_o.base_idx == REG_BP || dec_o.base_idx == REG_SP);
    end
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8
) (
  input  ea_dec_t                  dec_i,
  input  logic [NREG*DATA_W-1:0]   gpr_i,
  input  logic [DATA_W-1:0]        disp_i,
  input  logic                     addr32_i,
  output logic [DATA_W-1:0]        offset_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] gpr [NREG];
  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] index_val;
  logic [DATA_W-1:0] disp_val;
  logic [DATA_W-1:0] sum;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign gpr[g] = gpr_i[g*DATA_W +: DATA_W];
  end

  assign base_val  = dec_i.base_en  ? gpr[dec_i.base_idx] : '0;
  assign index_val = dec_i.index_en ? (gpr[dec_i.index_idx] << dec_i.scale) : '0;

  always_comb begin
    case (dec_i.dsz)
      DSZ_8:   disp_val = {{(DATA_W-8){disp_i[7]}}, disp_i[7:0]};
      DSZ_16:  disp_val = {{(DATA_W-HALF_W){1'b0}}, disp_i[HALF_W-1:0]};
      DSZ_32:  disp_val = disp_i;
      default: disp_val = '0;
    endcase
  end

  assign sum      = base_val + index_val + disp_val;
  assign offset_o = addr32_i ? sum : {{(DATA_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
endmodule

// File: rtl/ea_real_phys.sv
module ea_real_phys #(
  parameter int SEG_W  = 16,
  parameter int PHYS_W = 20
) (
  input  logic [SEG_W-1:0]  seg_val_i,
  input  logic [SEG_W-1:0]  offset_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int SHIFT = PHYS_W - SEG_W;

  assign phys_o = {seg_val_i, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, offset_i};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int SEG_W  = 16,
  parameter int NSEG   = 4,
  parameter int PHYS_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic [7:0]               modrm_i,
  input  logic [7:0]               sib_i,
  input  logic [DATA_W-1:0]        disp_i,
  input  logic                     addr32_i,
  input  logic [NREG*DATA_W-1:0]   gpr_i,
  input  logic [NSEG*SEG_W-1:0]    seg_vals_i,
  input  logic                     ovr_en_i,
  input  logic [1:0]               ovr_seg_i,
  output logic                     valid_o,
  output logic                     is_reg_o,
  output logic [2:0]               reg_num_o,
  output logic [2:0]               reg_field_o,
  output logic [DATA_W-1:0]        offset_o,
  output logic [1:0]               seg_o,
  output logic [PHYS_W-1:0]        phys_o,
  output logic [1:0]               disp_kind_o,
  output logic                     sib_used_o
);
  ea_dec_t           dec;
  logic [DATA_W-1:0] offset_c;
  logic [1:0]        seg_c;
  logic [SEG_W-1:0]  seg_vals [NSEG];
  logic [SEG_W-1:0]  seg_val_c;
  logic [PHYS_W-1:0] phys_c;

  for (genvar s = 0; s < NSEG; s++) begin : g_segs
    assign seg_vals[s] = seg_vals_i[s*SEG_W +: SEG_W];
  end

  ea_decode u_dec (
    .modrm_i  (modrm_i),
    .sib_i    (sib_i),
    .addr32_i (addr32_i),
    .dec_o    (dec)
  );

  ea_sum #(.DATA_W(DATA_W), .NREG(NREG)) u_sum (
    .dec_i    (dec),
    .gpr_i    (gpr_i),
    .disp_i   (disp_i),
    .addr32_i (addr32_i),
    .offset_o (offset_c)
  );

  assign seg_c     = ovr_en_i ? ovr_seg_i : (dec.stack_seg ? SEG_SS : SEG_DS);
  assign seg_val_c = seg_vals[seg_c];

  ea_real_phys #(.SEG_W(SEG_W), .PHYS_W(PHYS_W)) u_phys (
    .seg_val_i (seg_val_c),
    .offset_i  (offset_c[SEG_W-1:0]),
    .phys_o    (phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o     <= 1'b0;
      is_reg_o    <= 1'b0;
      reg_num_o   <= '0;
      reg_field_o <= '0;
      offset_o    <= '0;
      seg_o       <= '0;
      phys_o      <= '0;
      disp_kind_o <= '0;
      sib_used_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        is_reg_o    <= dec.is_reg;
        reg_num_o   <= dec.reg_num;
        reg_field_o <= modrm_i[5:3];
        disp_kind_o <= dec.dsz;
        sib_used_o  <= dec.sib_used;
        if (dec.is_reg) begin
          offset_o <= '0;
          seg_o    <= '0;
          phys_o   <= '0;
        end else begin
          offset_o <= offset_c;
          seg_o    <= seg_c;
          phys_o   <= phys_c;
        end
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int DATA_W = 32,
  parameter int SEG_W  = 16,
  parameter int NSEG   = 4,
  parameter int PHYS_W = 20
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  valid_i,
  input logic [7:0]            modrm_i,
  input logic                  addr32_i,
  input logic [NSEG*SEG_W-1:0] seg_vals_i,
  input logic                  ovr_en_i,
  input logic [1:0]            ovr_seg_i,
  input logic                  valid_o,
  input logic                  is_reg_o,
  input logic [2:0]            reg_num_o,
  input logic [DATA_W-1:0]     offset_o,
  input logic [1:0]            seg_o,
  input logic [PHYS_W-1:0]     phys_o,
  input logic [1:0]            disp_kind_o,
  input logic                  sib_used_o
);
  localparam int SHIFT = PHYS_W - SEG_W;
  localparam int HALF_W = DATA_W / 2;

  logic [NSEG*SEG_W-1:0] seen_segs;
  logic [SEG_W-1:0]      seen_val;

  always_ff @(posedge clk) begin
    if (rst) seen_segs <= '0;
    else if (valid_i) seen_segs <= seg_vals_i;
  end
  assign seen_val = seen_segs[seg_o*SEG_W +: SEG_W];

  p_valid_lag_r13: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  p_valid_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);
  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(offset_o) && $stable(phys_o) && $stable(seg_o) && $stable(is_reg_o));
  p_regop_r1: assert property (@(posedge clk) disable iff (rst)
    valid_i && modrm_i[7:6] == 2'b11 |=>
      is_reg_o && reg_num_o == $past(modrm_i[2:0]) && disp_kind_o == 2'd0 && offset_o == '0);
  p_disp8_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i && modrm_i[7:6] == 2'b01 |=> disp_kind_o == 2'd1);
  p_wrap16_r11: assert property (@(posedge clk) disable iff (rst)
    valid_i && !addr32_i |=> offset_o[DATA_W-1:HALF_W] == '0);
  p_override_r10: assert property (@(posedge clk) disable iff (rst)
    valid_i && ovr_en_i && modrm_i[7:6] != 2'b11 |=> seg_o == $past(ovr_seg_i));
  p_sib_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i && addr32_i && modrm_i[7:6] != 2'b11 && modrm_i[2:0] == 3'd4 |=> sib_used_o);
  p_phys_r12: assert property (@(posedge clk) disable iff (rst)
    valid_o && !is_reg_o |->
      phys_o == {seen_val, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, offset_o[SEG_W-1:0]});
endmodule

bind ea_gen ea_gen_chk #(
  .DATA_W(DATA_W), .SEG_W(SEG_W), .NSEG(NSEG), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .modrm_i(modrm_i),
  .addr32_i(addr32_i), .seg_vals_i(seg_vals_i), .ovr_en_i(ovr_en_i),
  .ovr_seg_i(ovr_seg_i), .valid_o(valid_o), .is_reg_o(is_reg_o),
  .reg_num_o(reg_num_o), .offset_o(offset_o), .seg_o(seg_o),
  .phys_o(phys_o), .disp_kind_o(disp_kind_o), .sib_used_o(sib_used_o)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         valid_i;
  logic [7:0]   modrm_i, sib_i;
  logic [31:0]  disp_i;
  logic         addr32_i;
  logic [255:0] gpr_i;
  logic [63:0]  seg_vals_i;
  logic         ovr_en_i;
  logic [1:0]   ovr_seg_i;
  logic         valid_o, is_reg_o, sib_used_o;
  logic [2:0]   reg_num_o, reg_field_o;
  logic [31:0]  offset_o;
  logic [1:0]   seg_o, disp_kind_o;
  logic [19:0]  phys_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected values
  longint e_off, e_phys;
  int     e_isreg, e_regn, e_regf, e_dk, e_seg, e_sib, e_valid;
  string  e_tag;

  always #2 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .modrm_i(modrm_i), .sib_i(sib_i),
    .disp_i(disp_i), .addr32_i(addr32_i), .gpr_i(gpr_i), .seg_vals_i(seg_vals_i),
    .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i), .valid_o(valid_o),
    .is_reg_o(is_reg_o), .reg_num_o(reg_num_o), .reg_field_o(reg_field_o),
    .offset_o(offset_o), .seg_o(seg_o), .phys_o(phys_o),
    .disp_kind_o(disp_kind_o), .sib_used_o(sib_used_o)
  );

  function automatic longint rv(int i);
    return longint'(gpr_i[i*32 +: 32]);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference of the requirements
  task automatic model();
    int md = modrm_i[7:6];
    int rm = modrm_i[2:0];
    longint off = 0;
    bit stack = 0;
    e_regf = modrm_i[5:3];
    e_sib = 0;
    if (md == 3) begin                      // R1
      e_isreg = 1; e_regn = rm; e_off = 0; e_dk = 0; e_seg = 0; e_phys = 0;
      e_tag = "R1";
      return;
    end
    e_isreg = 0; e_regn = 0; e_dk = md;
    if (!addr32_i) begin
      e_tag = "R3";
      case (rm)
        0: off = rv(3) + rv(6);
        1: off = rv(3) + rv(7);
        2: begin off = rv(5) + rv(6); stack = 1; end
        3: begin off = rv(5) + rv(7); stack = 1; end
        4: off = rv(6);
        5: off = rv(7);
        6: if (md == 0) begin off = disp_i[15:0]; e_dk = 2; e_tag = "R4"; end
           else begin off = rv(5); stack = 1; end
        default: off = rv(3);
      endcase
      if (md == 1) off += longint'($signed(disp_i[7:0]));
      if (md == 2) off += disp_i[15:0];
      off &= 64'hFFFF;
    end else begin
      if (rm == 4) begin
        int sc = sib_i[7:6], ix = sib_i[5:3], bs = sib_i[2:0];
        e_sib = 1; e_tag = (ix == 4) ? "R7" : "R6";
        if (ix != 4) off = (rv(ix) << sc);
        if (bs == 5 && md == 0) begin off += disp_i; e_dk = 3; e_tag = "R8"; end
        else begin off += rv(bs); stack = (bs == 4 || bs == 5); end
      end else if (rm == 5 && md == 0) begin
        off = disp_i; e_dk = 3; e_tag = "R5";
      end else begin
        off = rv(rm); stack = (rm == 5); e_tag = "R5";
      end
      if (md == 1) off += longint'($signed(disp_i[7:0]));
      if (md == 2) begin off += disp_i; e_dk = 3; end
      off &= 64'hFFFF_FFFF;
    end
    e_off = off;
    e_seg = ovr_en_i ? ovr_seg_i : (stack ? 2 : 3);
    e_phys = ((longint'(seg_vals_i[e_seg*16 +: 16]) << 4) + (off & 64'hFFFF)) & 64'hF_FFFF;
  endtask

  task automatic compare();
    string st;
    chk("R13 valid", valid_o, e_valid);
    chk("R1 is_reg", is_reg_o, e_isreg);
    chk("R1 reg_num", reg_num_o, e_regn);
    chk("R1 reg_field", reg_field_o, e_regf);
    chk("R2 disp_kind", disp_kind_o, e_dk);
    chk({e_tag, " offset"}, offset_o, e_off);
    st = ovr_en_i ? "R10 seg" : "R9 seg";
    chk(st, seg_o, e_seg);
    chk("R12 phys", phys_o, e_phys);
    chk("R6 sib_used", sib_used_o, e_sib);
    if (e_valid && !e_isreg && e_tag inside {"R3", "R4"})
      chk("R11 upper half", offset_o[31:16], 0);
  endtask

  // drive at negedge, compare one clock later at negedge
  task automatic step(bit v);
    valid_i = v;
    e_valid = v;
    if (v) model();
    @(negedge clk);
    compare();
  endtask

  task automatic setup(bit a32, logic [7:0] m, logic [7:0] s, logic [31:0] d);
    addr32_i = a32; modrm_i = m; sib_i = s; disp_i = d;
  endtask

  initial begin
    rst = 1; valid_i = 0; modrm_i = 0; sib_i = 0; disp_i = 0; addr32_i = 0;
    ovr_en_i = 0; ovr_seg_i = 0;
    for (int i = 0; i < 8; i++) gpr_i[i*32 +: 32] = 32'h1000_0100 * (i + 1) + 32'h11 * i;
    seg_vals_i = {16'h3000, 16'h2000, 16'h1000, 16'h0800};
    e_off = 0; e_phys = 0; e_isreg = 0; e_regn = 0; e_regf = 0; e_dk = 0;
    e_seg = 0; e_sib = 0; e_valid = 0; e_tag = "R13";
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare();                              // R13 reset state

    // R3/R4/R2: every 16-bit rm and mode, negative and positive disp8
    for (int md = 0; md < 4; md++)
      for (int rm = 0; rm < 8; rm++) begin
        setup(0, 8'(md*64 + rm*8 + rm), 8'hFF, (rm[0]) ? 32'h0000_12F0 : 32'h0000_9A7F);
        step(1);
      end
    // R5/R2: every 32-bit non-SIB rm and mode
    for (int md = 0; md < 4; md++)
      for (int rm = 0; rm < 8; rm++) if (rm != 4) begin
        setup(1, 8'(md*64 + rm), 8'h00, 32'hFFFF_FF80 + rm);
        step(1);
      end
    // R6/R7/R8: scale, index, base sweep
    for (int md = 0; md < 3; md++)
      for (int sc = 0; sc < 4; sc++)
        for (int ix = 0; ix < 8; ix += 2)
          for (int bs = 3; bs < 6; bs++) begin
            setup(1, 8'(md*64 + 4), 8'(sc*64 + ix*8 + bs), 32'h8000_0040);
            step(1);
          end
    setup(1, 8'h04, 8'b10_100_101, 32'h1234_5678); step(1);   // R7+R8 disp only
    // R10: override all codes
    for (int s = 0; s < 4; s++) begin
      ovr_en_i = 1; ovr_seg_i = 2'(s);
      setup(0, 8'h46, 8'h00, 32'h0000_0010); step(1);
    end
    ovr_en_i = 0;
    // R11/R12: wrap near top of range
    gpr_i[3*32 +: 32] = 32'hFFFF_FFF0; gpr_i[6*32 +: 32] = 32'h0000_0030;
    seg_vals_i[3*16 +: 16] = 16'hFFFF;
    setup(0, 8'h80, 8'h00, 32'h0000_FFF0); step(1);
    setup(1, 8'h83, 8'h00, 32'h0000_0100); step(1);
    // R13: hold while idle, inputs changing
    setup(1, 8'hC5, 8'h00, 32'h0); step(0);
    setup(0, 8'h00, 8'h00, 32'h5); step(0);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      gpr_i = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      seg_vals_i = {$urandom, $urandom};
      ovr_en_i = ($urandom % 4) == 0;
      ovr_seg_i = 2'($urandom);
      setup(1'($urandom), 8'($urandom), 8'($urandom), $urandom);
      step(($urandom % 5) != 0);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule